// File: doc/BRIEF.md
# Word Store Execution Unit

This unit carries out one class of 16-bit instruction: storing a full 32-bit register to memory. It accepts an instruction halfword through a valid/ready handshake and recognises two store encodings. In one, the address is the sum of two registers. In the other, it is a base register plus a 5-bit unsigned constant scaled by four. It reads its operands from a local 8-entry register file, which is loaded through a dedicated write port. It then forms the address and, when the alignment check input is high, rejects any address that is not word aligned.

An aligned store, or any store made while the check is off, is presented on a simple memory write port. The request is held until the memory accepts it, and then `done_o` pulses. A rejected store pulses `abort_o` and touches neither memory nor the register file. A halfword matching neither encoding pulses `unsupp_o` and does nothing else.

Top module: `wstore_unit`

## Requirements
- R1: A halfword whose bits [15:9] are 0101000 is a register-offset store, with index fields in bits [8:6] (offset register), [5:3] (base register) and [2:0] (data register); its address is base + offset register contents.
- R2: A halfword whose bits [15:11] are 01100 is an immediate store, with a 5-bit constant in bits [10:6], base in [5:3] and data register in [2:0]; its address is base + constant*4.
- R3: The write data is the full 32-bit content of the data register, and `mem_be_o` is 1111 while a request is up.
- R4: `mem_req_o` rises in the cycle after acceptance. Address, data and request hold stable until `mem_ready_i` is sampled high at a clock edge. `done_o` is high for exactly the following cycle, and the unit is then idle.
- R5: With `align_chk_i` high at acceptance and address bits [1:0] not 00, `abort_o` is high for exactly the cycle after acceptance and no request or `done_o` is issued.
- R6: With `align_chk_i` low, a misaligned address still produces exactly one write request followed by `done_o`, and no abort; its data is not specified.
- R7: Any halfword matching neither encoding makes `unsupp_o` high for exactly the cycle after acceptance, with no request, abort or done.
- R8: Address sums wrap modulo 2^32 with no overflow indication.
- R9: After reset, `instr_ready_o` is 1 and all other outputs are 0. `instr_ready_o` is high only when the unit is idle, and a halfword is accepted only on a clock edge with valid and ready both high.
- R10: An aborted store leaves every register-file entry unchanged.
- R11: A register-file write (`rf_we_i` high at an edge) is visible to every instruction accepted at a later edge; all entries reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction halfword |
| instr_valid_i | input | 1 | Instruction present |
| instr_ready_o | output | 1 | Unit idle, can accept |
| align_chk_i | input | 1 | Enable word-alignment fault |
| rf_we_i | input | 1 | Register-file write enable |
| rf_waddr_i | input | 3 | Register-file write index |
| rf_wdata_i | input | 32 | Register-file write data |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | 32 | Write address |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte strobes |
| mem_ready_i | input | 1 | Memory accepts request |
| done_o | output | 1 | Store completed pulse |
| abort_o | output | 1 | Alignment fault pulse |
| unsupp_o | output | 1 | Unrecognised encoding pulse |

## Verification
Every result is due one edge after acceptance. The request, abort or unsupported pulse is seen in the cycle after the edge that takes the halfword. `done_o` appears in the cycle after the first edge at which `mem_ready_i` is high. The bench drives and samples on falling edges and steps one clock at a time. At each step it checks exactly the output due in that cycle against a model computed from the register contents it has loaded. While `mem_ready_i` is held low, it also confirms on every cycle that the request stays unchanged.

// File: rtl/wstore_pkg.sv
package wstore_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NREG = 8;
  localparam int unsigned RA_W = $clog2(NREG);
  localparam int unsigned BE_W = XLEN / 8;
  localparam int unsigned IMM_W = 5;

  typedef enum logic [1:0] {OP_NONE, OP_REG, OP_IMM} op_kind_e;

  typedef enum logic [2:0] {S_IDLE, S_WR, S_DONE, S_ABT, S_UNS} st_e;

  typedef struct packed {
    op_kind_e          kind;
    logic [RA_W-1:0]   rm;
    logic [RA_W-1:0]   rn;
    logic [RA_W-1:0]   rd;
    logic [IMM_W-1:0]  imm;
  } dec_t;
endpackage

// File: rtl/wstore_decode.sv
module wstore_decode
  import wstore_pkg::*;
(
  input  logic [15:0] instr_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o.rm   = instr_i[8:6];
    dec_o.rn   = instr_i[5:3];
    dec_o.rd   = instr_i[2:0];
    dec_o.imm  = instr_i[10:6];
    if (instr_i[15:9] == 7'b0101000)      dec_o.kind = OP_REG;
    else if (instr_i[15:11] == 5'b01100)  dec_o.kind = OP_IMM;
    else                                  dec_o.kind = OP_NONE;
  end
endmodule

// File: rtl/wstore_regfile.sv
module wstore_regfile #(
  parameter int unsigned W    = 32,
  parameter int unsigned N    = 8,
  parameter int unsigned NRD  = 3,
  localparam int unsigned AW  = $clog2(N)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [W-1:0]            wdata_i,
  input  logic [NRD-1:0][AW-1:0]  raddr_i,
  output logic [NRD-1:0][W-1:0]   rdata_o
);
  logic [N-1:0][W-1:0] mem_q;

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))       mem_q[g] <= wdata_i;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r] = mem_q[raddr_i[r]];
  end
endmodule

// File: rtl/wstore_agen.sv
module wstore_agen
  import wstore_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  op_kind_e          kind_i,
  input  logic [W-1:0]      base_i,
  input  logic [W-1:0]      rm_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [W-1:0]      addr_o,
  output logic              misal_o
);
  logic [W-1:0] ofs;
  // immediate is a word count: scale by 4
  assign ofs     = (kind_i == OP_IMM) ? W'({imm_i, 2'b00}) : rm_val_i;
  assign addr_o  = base_i + ofs;
  assign misal_o = |addr_o[1:0];
endmodule

// File: rtl/wstore_unit.sv
module wstore_unit
  import wstore_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      instr_i,
  input  logic             instr_valid_i,
  output logic             instr_ready_o,
  input  logic             align_chk_i,
  input  logic             rf_we_i,
  input  logic [RA_W-1:0]  rf_waddr_i,
  input  logic [XLEN-1:0]  rf_wdata_i,
  output logic             mem_req_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  output logic [BE_W-1:0]  mem_be_o,
  input  logic             mem_ready_i,
  output logic             done_o,
  output logic             abort_o,
  output logic             unsupp_o
);
  localparam int unsigned NRD = 3;

  dec_t                       dec;
  logic [NRD-1:0][RA_W-1:0]   rd_idx;
  logic [NRD-1:0][XLEN-1:0]   rd_val;
  logic [XLEN-1:0]            ea;
  logic                       misal;
  logic                       accept;

  st_e             state_q, state_d;
  logic [XLEN-1:0] addr_q, data_q;

  wstore_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  assign rd_idx[0] = dec.rn;
  assign rd_idx[1] = dec.rm;
  assign rd_idx[2] = dec.rd;

  wstore_regfile #(.W(XLEN), .N(NREG), .NRD(NRD)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we_i),
    .waddr_i (rf_waddr_i),
    .wdata_i (rf_wdata_i),
    .raddr_i (rd_idx),
    .rdata_o (rd_val)
  );

  wstore_agen #(.W(XLEN)) u_agen (
    .kind_i   (dec.kind),
    .base_i   (rd_val[0]),
    .rm_val_i (rd_val[1]),
    .imm_i    (dec.imm),
    .addr_o   (ea),
    .misal_o  (misal)
  );

  assign instr_ready_o = (state_q == S_IDLE);
  assign accept        = instr_valid_i && instr_ready_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (accept) begin
        if (dec.kind == OP_NONE)       state_d = S_UNS;
        else if (align_chk_i && misal) state_d = S_ABT;
        else                           state_d = S_WR;
      end
      S_WR:   if (mem_ready_i) state_d = S_DONE;
      S_DONE, S_ABT, S_UNS: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept && dec.kind != OP_NONE) begin
        addr_q <= ea;
        data_q <= rd_val[2];
      end
    end
  end

  assign mem_req_o   = (state_q == S_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;
  assign mem_be_o    = mem_req_o ? '1 : '0;
  assign done_o      = (state_q == S_DONE);
  assign abort_o     = (state_q == S_ABT);
  assign unsupp_o    = (state_q == S_UNS);
endmodule

// File: rtl/wstore_unit_chk.sv
module wstore_unit_chk
  import wstore_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [15:0]      instr_i,
  input logic             instr_valid_i,
  input logic             instr_ready_o,
  input logic             align_chk_i,
  input logic             rf_we_i,
  input logic [RA_W-1:0]  rf_waddr_i,
  input logic [XLEN-1:0]  rf_wdata_i,
  input logic             mem_req_o,
  input logic [XLEN-1:0]  mem_addr_o,
  input logic [XLEN-1:0]  mem_wdata_o,
  input logic [BE_W-1:0]  mem_be_o,
  input logic             mem_ready_i,
  input logic             done_o,
  input logic             abort_o,
  input logic             unsupp_o
);
  a_r4_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o));

  a_r4_done_after_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i |=> done_o && !mem_req_o);

  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && instr_ready_o);

  a_r3_full_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_be_o == '1);

  a_r5_abort_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(align_chk_i && instr_valid_i && instr_ready_o));

  a_r5_abort_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o && !mem_req_o && !done_o);

  a_r5_no_misaligned_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) && $past(align_chk_i) |-> mem_addr_o[1:0] == 2'b00);

  a_r7_unsupp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsupp_o |-> $past(instr_valid_i && instr_ready_o) ##1 !unsupp_o && !mem_req_o);

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({instr_ready_o, mem_req_o, done_o, abort_o, unsupp_o}));

  a_r9_req_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(instr_valid_i && instr_ready_o));
endmodule

bind wstore_unit wstore_unit_chk u_chk (.*);

// File: tb/sim_wstore_unit.sv
`timescale 1ns/1ps
module sim_wstore_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr_i = '0;
  logic        instr_valid_i = 1'b0;
  logic        instr_ready_o;
  logic        align_chk_i = 1'b0;
  logic        rf_we_i = 1'b0;
  logic [2:0]  rf_waddr_i = '0;
  logic [31:0] rf_wdata_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [3:0]  mem_be_o;
  logic        mem_ready_i = 1'b0;
  logic        done_o, abort_o, unsupp_o;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] m_regs [8];

  always #2 clk_i = ~clk_i;

  wstore_unit u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  // 0 none, 1 register offset, 2 immediate
  function automatic int kind_of(input logic [15:0] i);
    if (i[15:9] == 7'b0101000) return 1;
    if (i[15:11] == 5'b01100)  return 2;
    return 0;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [15:0] i);
    if (kind_of(i) == 1) return m_regs[i[5:3]] + m_regs[i[8:6]];
    return m_regs[i[5:3]] + {25'd0, i[10:6], 2'b00};
  endfunction

  function automatic logic [15:0] enc_reg(input int rm, input int rn, input int rd);
    return 16'h5000 | 16'(rm << 6) | 16'(rn << 3) | 16'(rd);
  endfunction

  function automatic logic [15:0] enc_imm(input int imm, input int rn, input int rd);
    return 16'h6000 | 16'(imm << 6) | 16'(rn << 3) | 16'(rd);
  endfunction

  task automatic set_reg(input int idx, input logic [31:0] v);
    rf_we_i = 1'b1; rf_waddr_i = 3'(idx); rf_wdata_i = v;
    @(posedge clk_i); @(negedge clk_i);
    rf_we_i = 1'b0;
    m_regs[idx] = v;
  endtask

  // called at a falling edge with the unit idle
  task automatic run(input string tag, input logic [15:0] ins, input logic chk, input int dly);
    int k;
    logic [31:0] ea, dv, a0;
    k  = kind_of(ins);
    ea = (k != 0) ? exp_addr(ins) : 32'd0;
    dv = m_regs[ins[2:0]];
    check({tag, " R9 ready"}, 32'(instr_ready_o), 32'd1);
    instr_i = ins; instr_valid_i = 1'b1; align_chk_i = chk;
    @(posedge clk_i); @(negedge clk_i);
    instr_valid_i = 1'b0; instr_i = $urandom();
    check({tag, " R9 busy"}, 32'(instr_ready_o), 32'd0);
    if (k == 0) begin
      check({tag, " R7 unsupp"}, 32'({unsupp_o, mem_req_o, abort_o, done_o}), 32'b1000);
      @(posedge clk_i); @(negedge clk_i);
      check({tag, " R7 pulse"}, 32'({unsupp_o, mem_req_o, instr_ready_o}), 32'b001);
    end else if (chk && ea[1:0] != 2'b00) begin
      check({tag, " R5 abort"}, 32'({abort_o, mem_req_o, done_o, unsupp_o}), 32'b1000);
      @(posedge clk_i); @(negedge clk_i);
      check({tag, " R5 pulse"}, 32'({abort_o, mem_req_o, done_o, instr_ready_o}), 32'b0001);
    end else begin
      check({tag, " R4 req"}, 32'({mem_req_o, abort_o, unsupp_o}), 32'b100);
      check({tag, " R3 be"}, 32'(mem_be_o), 32'hF);
      a0 = mem_addr_o;
      if (ea[1:0] == 2'b00) begin
        check({tag, (k == 1) ? " R1 addr" : " R2 addr"}, mem_addr_o, ea);
        check({tag, " R3 data"}, mem_wdata_o, dv);
      end else begin
        check({tag, " R6 no abort"}, 32'(abort_o), 32'd0);
      end
      for (int c = 0; c < dly; c++) begin
        @(posedge clk_i); @(negedge clk_i);
        check({tag, " R4 hold"}, 32'({mem_req_o, done_o}), 32'b10);
        check({tag, " R4 addr stable"}, mem_addr_o, a0);
      end
      mem_ready_i = 1'b1;
      @(posedge clk_i); @(negedge clk_i);
      mem_ready_i = 1'b0;
      check({tag, " R4 done"}, 32'({done_o, mem_req_o}), 32'b10);
      @(posedge clk_i); @(negedge clk_i);
      check({tag, " R4 done pulse"}, 32'({done_o, mem_req_o, instr_ready_o}), 32'b001);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_err++;
    $display("FAIL R4 watchdog expired act=0 exp=1");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] ins;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) m_regs[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 reset state
    check("R9 reset ready", 32'(instr_ready_o), 32'd1);
    check("R9 reset outputs", 32'({mem_req_o, done_o, abort_o, unsupp_o}), 32'd0);
    // R11 reset contents are zero
    run("R11 reset regs", enc_reg(1, 2, 3), 1'b1, 0);

    // directed corners
    set_reg(0, 32'h0000_1000); set_reg(1, 32'h0000_0010); set_reg(2, 32'hDEAD_BEEF);
    run("R1 basic", enc_reg(1, 0, 2), 1'b1, 2);
    run("R2 imm max", enc_imm(31, 0, 2), 1'b1, 0);
    set_reg(3, 32'hFFFF_FFFC); set_reg(4, 32'h0000_0008);
    run("R8 wrap reg", enc_reg(4, 3, 2), 1'b1, 1);
    run("R8 wrap imm", enc_imm(3, 3, 2), 1'b1, 0);
    run("R1 same reg", enc_reg(3, 3, 3), 1'b1, 0);
    set_reg(5, 32'h0000_2002);
    set_reg(6, 32'h1234_5678);
    run("R5 misal reg", enc_reg(5, 0, 6), 1'b1, 0);
    run("R5 misal imm", enc_imm(7, 5, 6), 1'b1, 0);
    // R10 contents after abort
    run("R10 after abort", enc_imm(0, 0, 6), 1'b1, 0);
    run("R10 rn intact", enc_imm(0, 0, 5), 1'b1, 0);
    run("R6 misal unchecked", enc_reg(5, 0, 6), 1'b0, 3);
    run("R7 near reg", 16'h5200, 1'b1, 0);
    run("R7 near imm", 16'h6800, 1'b1, 0);
    run("R7 zero", 16'h0000, 1'b1, 0);
    // R11 newest write visible
    set_reg(2, 32'hCAFE_F00D);
    run("R11 update", enc_imm(4, 0, 2), 1'b1, 0);

    // R9 no accept without valid
    repeat (3) begin
      @(posedge clk_i); @(negedge clk_i);
      check("R9 idle no valid", 32'({mem_req_o, done_o, abort_o, unsupp_o}), 32'd0);
    end

    for (int it = 0; it < 400; it++) begin
      int sel;
      if ($urandom_range(0, 2) == 0) begin
        int idx;
        idx = $urandom_range(0, 7);
        set_reg(idx, ($urandom_range(0, 1) == 1) ? ($urandom() & 32'hFFFF_FFFC) : $urandom());
      end
      sel = $urandom_range(0, 4);
      if (sel < 2)      ins = enc_reg($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
      else if (sel < 4) ins = enc_imm($urandom_range(0, 31), $urandom_range(0, 7), $urandom_range(0, 7));
      else              ins = 16'($urandom());
      run("rand", ins, 1'($urandom_range(0, 1)), $urandom_range(0, 3));
    end

    summary();
    $finish;
  end
endmodule